// File: doc/BRIEF.md
# Reloadable interval timer with packed byte readback

This block is a periodic timer meant for a board-control logic device. A host talks to it over a plain byte-wide register bus with an address, a write strobe, a read strobe and separate write and read data. An up-counter advances at a fixed 33 MHz tick. When the counter arrives at the programmed reload value it starts again from zero. If interrupts are enabled, that wrap drives a level interrupt line. Software acknowledges the interrupt by writing the interrupt-enable bit low and then high again.

A strap input tells the block whether its clock is 33 MHz or 66 MHz. When the strap is high, the counter advances on every second clock, so the count rate does not change. The reload value is written as three contiguous bytes. The count is read as four bytes in a sparse packed format. Reading the lowest byte takes a snapshot of the whole count, so the three bytes that follow belong to that same instant. The counter width is a parameter: 22 bits by default, with narrower variants such as 19 bits.

Top module: `interval_timer`

## Requirements
- R1: A synchronous reset clears the counter, the reload value, both enable bits, the pending interrupt and the read data. After reset, every readable address returns 0 and `irq_o` is low.
- R2: With `fast_clk_i` low, the counter advances on every clock while counting is enabled. With `fast_clk_i` high, it advances on every second clock.
- R3: On an advance, if count+1 is greater than or equal to the reload value, the counter becomes 0 (a wrap). Otherwise it increments. The period is therefore `reload` advances, and a reload of 0 or 1 keeps the counter at 0.
- R4: A wrap while interrupt enable is 1 raises `irq_o`. The line stays high until it is cleared.
- R5: Interrupt enable is bit 1 of the control register. Writing it as 0 clears `irq_o` at that same clock edge. While it is 0, wraps leave no pending interrupt.
- R6: While counting enable (control bit 0) is 0, the counter holds its value.
- R7: Reload writes: address 0 sets bits 7:0, address 1 sets bits 15:8, and address 2 sets bits 21:16 from data bits 5:0. Data bits 7:6 at address 2, and any bits above the counter width, are dropped.
- R8: A reload write while counting is disabled resets the counter to 0. While counting is enabled, a reload write does not disturb the count.
- R9: A read of address 0 returns the live count and snapshots it. Reads of addresses 1 to 3 return bytes of the latest snapshot.
- R10: Count byte k (k = 0..2) reads as {0, c[6k+5], 0, c[6k+4:6k]}. Byte 3 reads as {4'b0, c[21:18]}. Count bits above the counter width read as 0.
- R11: Address 4 is the control register: bit 0 is count enable, bit 1 is interrupt enable, and both read back with bits 7:2 as 0. Addresses 5 to 7 read 0 and ignore writes.
- R12: Read data is registered. It appears the clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, 33 or 66 MHz |
| rst_i | input | 1 | Synchronous active-high reset |
| fast_clk_i | input | 1 | Strap: high when `clk_i` runs at 66 MHz |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong count or a wrong reload value shows up the next time software reads the count or the interrupt rises. In the worst case that is one timer period later, so the bench keeps reload values small to make wraps frequent. A prescaler that is out of phase shows up within two clocks as a count step that arrives early or late. A bad snapshot shows up on the first multi-byte read, because the bench spaces reads of the upper bytes well apart from the low-byte read. Errors in the interrupt state appear on `irq_o` on the clock after the wrap or the enable write that caused them.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   localparam int FULL_W   = 22;
   localparam int DATA_W   = 8;
   localparam int ADDR_W   = 3;
   localparam int SLICE_W  = 6;
   localparam int N_SLICED = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CNT0 = 3'd0,
      REG_CNT1 = 3'd1,
      REG_CNT2 = 3'd2,
      REG_CNT3 = 3'd3,
      REG_CTRL = 3'd4
   } ivt_reg_e;

   typedef struct packed {
      logic irq_en;
      logic cnt_en;
   } ivt_ctrl_t;

   // six count bits spread over a byte: low five at 4:0, sixth at 6
   function automatic logic [DATA_W-1:0] pack_slice(input logic [SLICE_W-1:0] s);
      return {1'b0, s[5], 1'b0, s[4:0]};
   endfunction
endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
   parameter int DIV_FAST = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic fast_i,
   output logic tick_o
);
   localparam int PH_W = (DIV_FAST > 1) ? $clog2(DIV_FAST) : 1;

   logic [PH_W-1:0] phase_q;

   generate
      if (DIV_FAST < 2) begin : g_nodiv
         assign tick_o = 1'b1;
         always_ff @(posedge clk_i) phase_q <= '0;
      end else begin : g_div
         localparam logic [PH_W-1:0] LAST = PH_W'(DIV_FAST - 1);
         always_ff @(posedge clk_i) begin
            if (rst_i || !fast_i)    phase_q <= '0;
            else if (phase_q == LAST) phase_q <= '0;
            else                      phase_q <= phase_q + 1'b1;
         end
         assign tick_o = fast_i ? (phase_q == LAST) : 1'b1;
      end
   endgenerate
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = 22
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] count_q;
   logic [EXT_W-1:0] next_ext;
   logic             adv;

   assign adv      = tick_i && run_i;
   assign next_ext = {1'b0, count_q} + EXT_W'(1);
   assign wrap_o   = adv && (next_ext >= {1'b0, reload_i});

   always_ff @(posedge clk_i) begin
      if (rst_i || clr_i) count_q <= '0;
      else if (adv) begin
         if (wrap_o) count_q <= '0;
         else        count_q <= next_ext[CNT_W-1:0];
      end
   end

   assign count_o = count_q;
endmodule

// File: rtl/ivt_readback.sv
module ivt_readback
   import ivt_pkg::*;
#(
   parameter int CNT_W = 22
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  count_i,
   input  ivt_ctrl_t         ctrl_i,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int TOP_W = FULL_W - N_SLICED * SLICE_W;

   logic [FULL_W-1:0] live_ext;
   logic [FULL_W-1:0] snap_q;
   logic [DATA_W-1:0] snap_byte [N_SLICED+1];
   logic [DATA_W-1:0] live_b0;
   logic [DATA_W-1:0] rdata_q;

   generate
      if (CNT_W < FULL_W) begin : g_pad
         assign live_ext = {{(FULL_W-CNT_W){1'b0}}, count_i};
      end else begin : g_full
         assign live_ext = count_i;
      end

      for (genvar k = 0; k < N_SLICED; k++) begin : g_slice
         assign snap_byte[k] = pack_slice(snap_q[k*SLICE_W +: SLICE_W]);
      end
   endgenerate

   assign snap_byte[N_SLICED] = {{(DATA_W-TOP_W){1'b0}}, snap_q[FULL_W-1 -: TOP_W]};
   assign live_b0             = pack_slice(live_ext[SLICE_W-1:0]);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         snap_q  <= '0;
         rdata_q <= '0;
      end else if (rd_i) begin
         case (addr_i)
            REG_CNT0: begin
               snap_q  <= live_ext;
               rdata_q <= live_b0;
            end
            REG_CNT1: rdata_q <= snap_byte[1];
            REG_CNT2: rdata_q <= snap_byte[2];
            REG_CNT3: rdata_q <= snap_byte[3];
            REG_CTRL: rdata_q <= {{(DATA_W-2){1'b0}}, ctrl_i};
            default:  rdata_q <= '0;
         endcase
      end
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import ivt_pkg::*;
#(
   parameter int CNT_W    = 22,
   parameter int DIV_FAST = 2
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       fast_clk_i,
   input  logic [2:0] addr_i,
   input  logic       wr_i,
   input  logic       rd_i,
   input  logic [7:0] wdata_i,
   output logic [7:0] rdata_o,
   output logic       irq_o
);
   generate
      if (CNT_W < 8 || CNT_W > FULL_W) begin : g_bad_width
         $error("interval_timer: CNT_W must be in 8..22");
      end
      if (DIV_FAST < 1) begin : g_bad_div
         $error("interval_timer: DIV_FAST must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]  reload_q;
   logic [FULL_W-1:0] reload_ext;
   logic [FULL_W-1:0] reload_new;
   logic [CNT_W-1:0]  count_q;
   ivt_ctrl_t         ctrl_q;
   ivt_ctrl_t         ctrl_d;
   logic              pend_q;
   logic              tick;
   logic              wrap;
   logic              reload_wr;
   logic              ctrl_wr;
   logic              cnt_en_q;
   logic              irq_en_q;

   assign ctrl_wr   = wr_i && (addr_i == REG_CTRL);
   assign reload_wr = wr_i && (addr_i <= REG_CNT2);
   assign cnt_en_q  = ctrl_q.cnt_en;
   assign irq_en_q  = ctrl_q.irq_en;

   always_comb begin
      ctrl_d = ctrl_q;
      if (ctrl_wr) begin
         ctrl_d.cnt_en = wdata_i[0];
         ctrl_d.irq_en = wdata_i[1];
      end
   end

   generate
      if (CNT_W < FULL_W) begin : g_rl_pad
         assign reload_ext = {{(FULL_W-CNT_W){1'b0}}, reload_q};
      end else begin : g_rl_full
         assign reload_ext = reload_q;
      end
   endgenerate

   always_comb begin
      reload_new = reload_ext;
      if (wr_i) begin
         case (addr_i)
            REG_CNT0: reload_new[7:0]   = wdata_i;
            REG_CNT1: reload_new[15:8]  = wdata_i;
            REG_CNT2: reload_new[21:16] = wdata_i[5:0];
            default:  reload_new        = reload_ext;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         reload_q <= '0;
         ctrl_q   <= '0;
         pend_q   <= 1'b0;
      end else begin
         reload_q <= reload_new[CNT_W-1:0];
         ctrl_q   <= ctrl_d;
         pend_q   <= ctrl_d.irq_en ? (pend_q | wrap) : 1'b0;
      end
   end

   ivt_tick_gen #(.DIV_FAST(DIV_FAST)) u_tick (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .fast_i (fast_clk_i),
      .tick_o (tick)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .tick_i   (tick),
      .run_i    (cnt_en_q),
      .clr_i    (reload_wr && !cnt_en_q),
      .reload_i (reload_q),
      .count_o  (count_q),
      .wrap_o   (wrap)
   );

   ivt_readback #(.CNT_W(CNT_W)) u_rb (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .rd_i    (rd_i),
      .addr_i  (addr_i),
      .count_i (count_q),
      .ctrl_i  (ctrl_q),
      .rdata_o (rdata_o)
   );

   assign irq_o = pend_q;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
   parameter int CNT_W = 22
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             fast_clk_i,
   input logic             tick,
   input logic             wrap,
   input logic             reload_wr,
   input logic             cnt_en_q,
   input logic             irq_en_q,
   input logic [CNT_W-1:0] count_q,
   input logic             irq_o,
   input logic [7:0]       rdata_o
);
   assert_tick_alt_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (fast_clk_i && tick) |=> (!fast_clk_i || !tick));

   assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      wrap |=> (count_q == '0));

   assert_irq_cause_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(irq_o) |-> $past(wrap));

   assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> irq_en_q);

   assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!cnt_en_q && !reload_wr) |=> $stable(count_q));

   assert_pad_zero_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      !rdata_o[7]);
endmodule

bind interval_timer ivt_checker #(.CNT_W(CNT_W)) u_ivt_chk (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .fast_clk_i (fast_clk_i),
   .tick       (tick),
   .wrap       (wrap),
   .reload_wr  (reload_wr),
   .cnt_en_q   (cnt_en_q),
   .irq_en_q   (irq_en_q),
   .count_q    (count_q),
   .irq_o      (irq_o),
   .rdata_o    (rdata_o)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
   localparam int W = 22;

   logic       clk = 1'b0;
   logic       rst;
   logic       fast;
   logic [2:0] addr;
   logic       wr, rd;
   logic [7:0] wd;
   logic [7:0] rdata;
   logic       irq;

   int total = 0;
   int bad   = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   interval_timer #(.CNT_W(W)) i_interval_timer (
      .clk_i(clk), .rst_i(rst), .fast_clk_i(fast), .addr_i(addr),
      .wr_i(wr), .rd_i(rd), .wdata_i(wd), .rdata_o(rdata), .irq_o(irq)
   );

   // ---------------- reference model built from the requirements ----------
   logic [W-1:0]  m_cnt, m_rel;
   logic          m_ph, m_cen, m_ien, m_pend;
   logic [21:0]   m_snap;
   logic [7:0]    m_rd;
   logic          t_b, w_b, cen_n, ien_n;
   logic [21:0]   rl_b;

   function automatic logic [7:0] pk(input logic [21:0] v, input int b);
      if (b == 3) return {4'b0, v[21:18]};
      return {1'b0, v[6*b+5], 1'b0, v[6*b+4 -: 5]};
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt <= '0; m_rel <= '0; m_ph <= 1'b0; m_cen <= 1'b0;
         m_ien <= 1'b0; m_pend <= 1'b0; m_snap <= '0; m_rd <= '0;
      end else begin
         t_b  = fast ? m_ph : 1'b1;
         m_ph <= fast ? ~m_ph : 1'b0;
         w_b  = t_b && m_cen && (({1'b0, m_cnt} + 1) >= {1'b0, m_rel});
         if (wr && addr <= 3'd2 && !m_cen) m_cnt <= '0;
         else if (t_b && m_cen)            m_cnt <= w_b ? '0 : m_cnt + 1'b1;
         rl_b = 22'(m_rel);
         if (wr) begin
            if (addr == 3'd0) rl_b[7:0]   = wd;
            if (addr == 3'd1) rl_b[15:8]  = wd;
            if (addr == 3'd2) rl_b[21:16] = wd[5:0];
         end
         m_rel <= rl_b[W-1:0];
         cen_n = (wr && addr == 3'd4) ? wd[0] : m_cen;
         ien_n = (wr && addr == 3'd4) ? wd[1] : m_ien;
         m_cen  <= cen_n;
         m_ien  <= ien_n;
         m_pend <= ien_n ? (m_pend | w_b) : 1'b0;
         if (rd) begin
            case (addr)
               3'd0: begin m_snap <= 22'(m_cnt); m_rd <= pk(22'(m_cnt), 0); end
               3'd1, 3'd2, 3'd3: m_rd <= pk(m_snap, int'(addr));
               3'd4: m_rd <= {6'b0, m_ien, m_cen};
               default: m_rd <= 8'h00;
            endcase
         end
      end
   end

   // ---------------- checking helpers -------------------------------------
   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      check({24'b0, rdata}, {24'b0, m_rd}, {cur_req, " rdata vs model"});
      check({31'b0, irq}, {31'b0, m_pend}, {cur_req, " irq vs model"});
   endtask

   // one bus cycle: drive at a falling edge, compare at the next falling edge
   task automatic op(input logic [2:0] a, input logic w, input logic r, input logic [7:0] d);
      addr = a; wr = w; rd = r; wd = d;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      cmp_model();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) op(3'd0, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic wreg(input logic [2:0] a, input logic [7:0] d); op(a, 1'b1, 1'b0, d); endtask
   task automatic rreg(input logic [2:0] a); op(a, 1'b0, 1'b1, 8'h00); endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
   end

   logic [7:0] v1, v2;
   int         wait_n;

   initial begin
      void'($urandom(32'd20240611));
      rst = 1'b1; fast = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0; wd = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      cur_req = "R1";
      check({31'b0, irq}, 0, "R1 irq after reset");
      rreg(3'd4); check({24'b0, rdata}, 0, "R1 ctrl after reset");
      rreg(3'd0); check({24'b0, rdata}, 0, "R1 count after reset");
      rreg(3'd3); check({24'b0, rdata}, 0, "R1 byte3 after reset");

      // R11: control register and unmapped space
      cur_req = "R11";
      wreg(3'd4, 8'hFC); rreg(3'd4); check({24'b0, rdata}, 0, "R11 ctrl upper bits");
      wreg(3'd6, 8'hFF); rreg(3'd4); check({24'b0, rdata}, 0, "R11 unmapped write");
      rreg(3'd5); check({24'b0, rdata}, 0, "R11 unmapped read");

      // R7 R3 R4: reload 5, upper bits of byte 2 dropped
      cur_req = "R7";
      wreg(3'd0, 8'h05); wreg(3'd1, 8'h00); wreg(3'd2, 8'hC0);
      cur_req = "R3";
      wreg(3'd4, 8'h03);
      idle(4); check({31'b0, irq}, 0, "R3 no wrap before period");
      idle(1); check({31'b0, irq}, 1, "R4 irq after reload advances");
      idle(3); check({31'b0, irq}, 1, "R4 irq level holds");

      // R5: acknowledge
      cur_req = "R5";
      wreg(3'd4, 8'h01); check({31'b0, irq}, 0, "R5 cleared on enable low");
      idle(12);          check({31'b0, irq}, 0, "R5 no pending while disabled");
      wreg(3'd4, 8'h03); idle(6);

      // R6: hold while stopped
      cur_req = "R6";
      wreg(3'd4, 8'h00);
      rreg(3'd0); v1 = rdata; idle(7);
      rreg(3'd0); check({24'b0, rdata}, {24'b0, v1}, "R6 count holds");

      // R8: reload write clears a stopped counter
      cur_req = "R8";
      wreg(3'd0, 8'h30); rreg(3'd0); check({24'b0, rdata}, 0, "R8 stopped reload clears");

      // R9 R12: snapshot stability and registered read data
      cur_req = "R9";
      wreg(3'd4, 8'h01); idle(9);
      rreg(3'd0); rreg(3'd1); v1 = rdata;
      idle(11);
      cur_req = "R12";
      check({24'b0, rdata}, {24'b0, v1}, "R12 read data holds");
      rreg(3'd1); check({24'b0, rdata}, {24'b0, v1}, "R9 snapshot byte1 stable");

      // R2: advance rate with and without the strap
      cur_req = "R2";
      wreg(3'd4, 8'h00); wreg(3'd0, 8'h00); wreg(3'd1, 8'h10);
      wreg(3'd4, 8'h01); idle(1);
      rreg(3'd0); v1 = rdata; idle(9);
      rreg(3'd0); v2 = rdata;
      check({24'b0, v2 - v1}, 10, "R2 one advance per clock");
      wreg(3'd4, 8'h00); wreg(3'd0, 8'h00);
      fast = 1'b1; wreg(3'd4, 8'h01); idle(2);
      rreg(3'd0); v1 = rdata; idle(9);
      rreg(3'd0); v2 = rdata;
      check({24'b0, v2 - v1}, 5, "R2 strap halves the rate");
      fast = 1'b0;

      // R10: large reload, run long, check packed fields
      cur_req = "R10";
      wreg(3'd2, 8'h3F); wreg(3'd4, 8'h01); idle(300);
      for (int b = 0; b < 4; b++) begin
         rreg(3'(b));
         check({24'b0, rdata & ((b == 3) ? 8'hF0 : 8'hA0)}, 0, "R10 unused bits zero");
      end

      // constrained random mix, reloads kept small so wraps are frequent
      cur_req = "R4";
      wreg(3'd4, 8'h00); wreg(3'd2, 8'h00); wreg(3'd1, 8'h00); wreg(3'd0, 8'h09);
      for (int n = 0; n < 6000; n++) begin
         logic [2:0] a;
         logic [7:0] d;
         int         kind;
         kind = $urandom % 100;
         a    = 3'($urandom % 8);
         d    = 8'($urandom);
         if ($urandom % 100 == 0) fast = ~fast;
         if (kind < 15) begin
            if (a == 3'd1 || a == 3'd2) d = ($urandom % 8 == 0) ? 8'h01 : 8'h00;
            if (a == 3'd0) d = 8'($urandom % 40);
            wreg(a, d);
         end else if (kind < 60) begin
            rreg(a);
            if (a <= 3'd2) check({24'b0, rdata & 8'hA0}, 0, "R10 random pad bits");
         end else begin
            idle(1);
         end
      end
      summary();
   end
endmodule